// File: doc/BRIEF.md
# Peripheral Bridge with Access Protection

This block joins a 64-bit system bus master port to a set of 32-bit peripheral slave ports. The master issues one request at a time: a byte, halfword or word read or write, or a 64-bit instruction fetch. The bridge decodes the address to one peripheral slot and drives that slave's valid/ready handshake. It then returns a single response to the master, carrying read data and an error flag. A fetch becomes two slave reads, and the bridge joins the two words before it responds.

A small register file inside the bridge sets the access rules. One register holds a trust and privilege field for each master ID. The access control registers hold one field for each peripheral module. A module field can turn on write buffering, limit the module to supervisor access, block writes, or deny untrusted masters. A request that breaks a rule gets an error response, and no handshake is started on any slave. With buffering on, a write is answered at once and then drained to the slave. Every later request waits until that drain is done.

Top module: `periph_bridge`

## Requirements
- R1: After reset the register at offset 0x00 reads 0x7777_7777, the one at 0x20 reads 0x5444_4444, and the four at 0x40, 0x44, 0x48 and 0x4C each read 0x4444_4444.
- R2: Address bit 15 set selects register space, where bits 14:0 are the offset and bit 2 picks the data lane. A supervisor write updates only the bytes whose enables are set. In the master register, each field's bit 3 always reads 0 and ignores writes.
- R3: Register space returns an error and leaves every register unchanged for any of these: a user-mode access, an offset other than the six above, or a fetch.
- R4: Address bit 15 clear selects slave space: bits 13:12 give the slot and bits 11:0 give the slave address. A request gets an error if bit 14 is set, or if address bits 1:0 are nonzero.
- R5: On single accesses, address bit 2 selects a 32-bit lane, and that lane's byte enables and write data go to the slave unchanged. Read data is returned on both lanes.
- R6: A fetch first reads the word at the address with bit 2 cleared, then the word with bit 2 set. The response data is {upper word, lower word}, and an error from either half sets the error flag.
- R7: A master counts as supervisor only when its privilege input is high and bit 0 of its master field is set. A module whose field bit 2 is set rejects requests that are not supervisor.
- R8: A module whose field bit 1 is set rejects writes and still serves reads.
- R9: A module whose field bit 0 is set rejects reads from masters whose field bit 2 is clear, and writes from masters whose field bit 1 is clear.
- R10: A rejected request drives no slave valid. Its error response appears in the cycle after acceptance.
- R11: A write to a module whose field bit 3 is set gets an error-free response before the slave handshake completes. An error returned by the slave for that write is dropped.
- R12: While a buffered write is still draining, master ready stays low. A read issued right after the buffered write returns the newly written data.
- R13: For an unbuffered access, the slave's error flag is returned to the master as its error.
- R14: At most one slave valid is high at a time, and it stays high with a stable address until that slave raises ready.

Module fields sit at bits [4s+3:4s] of the chain formed by register 0x20 followed by the registers at 0x40 to 0x4C. Master fields sit at bits [4m+3:4m] of register 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mValid | input | 1 | Master request valid |
| mReady | output | 1 | Bridge accepts the request this cycle |
| mWrite | input | 1 | Request is a write |
| mFetch | input | 1 | Request is a 64-bit instruction fetch |
| mMaster | input | 3 | Master ID |
| mSuper | input | 1 | Master runs in supervisor mode |
| mAddr | input | 16 | Request address |
| mBe | input | 8 | Byte enables over the 64-bit bus |
| mWdata | input | 64 | Write data |
| mRspValid | output | 1 | Response valid, one cycle |
| mRdata | output | 64 | Response read data |
| mErr | output | 1 | Response error |
| sValid | output | 4 | Per-slave request valid |
| sReady | input | 4 | Per-slave completion |
| sWrite | output | 1 | Slave access is a write |
| sAddr | output | 12 | Slave word address |
| sBe | output | 4 | Slave byte enables |
| sWdata | output | 32 | Slave write data |
| sRdata | input | 128 | Slave read data, 32 bits per slave |
| sErr | input | 4 | Slave error, one per slave |

## Verification
The assertions assume three things about the environment. A slave raises ready only while its own valid is high. The master holds its request fields steady until accepted. Byte enables fall inside the 32-bit lane chosen by address bit 2. The bench slave model raises ready only after its valid has been high for a set delay. The directed tasks drive each request from one negedge until acceptance and only set enables inside the addressed lane. Slave latency is raised for the buffered-write tests, so the early response and the blocked follow-up request can both be seen.

// File: rtl/pb_pkg.sv
package pb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_ACC2,
    ST_RESP,
    ST_DRAIN
  } pbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic regWr;
    logic loadLo;
    logic loadHi;
    logic hiHalf;
    logic drive;
  } pbStrobe_t;

  // verdict on the request presented at the master port
  typedef struct packed {
    logic isReg;
    logic bad;
    logic post;
  } pbDecide_t;

  localparam logic [31:0] MP_RESET  = 32'h7777_7777;
  localparam logic [31:0] PA_RESET  = 32'h5444_4444;
  localparam logic [31:0] OP_RESET  = 32'h4444_4444;
  localparam logic [31:0] MP_MASK   = 32'h7777_7777;

endpackage

// File: rtl/pb_datapath.sv
module pb_datapath
  import pb_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 16,
  parameter int SLV_AW  = 12,
  parameter int MST_W   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pbStrobe_t             stb,
  input  logic                  mWrite,
  input  logic                  mFetch,
  input  logic [MST_W-1:0]      mMaster,
  input  logic                  mSuper,
  input  logic [ADDR_W-1:0]     mAddr,
  input  logic [7:0]            mBe,
  input  logic [63:0]           mWdata,
  output pbDecide_t             dec,
  output logic                  reqFetch,
  output logic                  selReady,
  output logic [63:0]           mRdata,
  output logic                  mErr,
  output logic [NUM_SLV-1:0]    sValid,
  input  logic [NUM_SLV-1:0]    sReady,
  output logic                  sWrite,
  output logic [SLV_AW-1:0]     sAddr,
  output logic [3:0]            sBe,
  output logic [31:0]           sWdata,
  input  logic [NUM_SLV*32-1:0] sRdata,
  input  logic [NUM_SLV-1:0]    sErr
);

  localparam int SLOT_W  = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1;
  localparam int HI_W    = ADDR_W - 1 - SLV_AW - SLOT_W;
  localparam int OFF_W   = ADDR_W - 3;
  localparam int OP_N    = 4;
  localparam int ACL_W   = 32 * (OP_N + 1);

  // register file
  logic [31:0] mpcr;
  logic [31:0] pacr0;
  logic [31:0] opacr [OP_N];
  logic [ACL_W-1:0] aclFlat;

  always_comb begin
    aclFlat = '0;
    aclFlat[31:0] = pacr0;
    for (int i = 0; i < OP_N; i++) aclFlat[32*(i+1) +: 32] = opacr[i];
  end

  // lane selection
  logic [31:0] laneWd;
  logic [3:0]  laneBe;
  assign laneWd = mAddr[2] ? mWdata[63:32] : mWdata[31:0];
  assign laneBe = mAddr[2] ? mBe[7:4] : mBe[3:0];

  // register offset decode
  logic [OFF_W-1:0] offW;
  logic isMp, isPa, isOp, offOk;
  logic [1:0] opIdx;
  assign offW  = mAddr[ADDR_W-2:2];
  assign isMp  = (offW == OFF_W'(0));
  assign isPa  = (offW == OFF_W'(8));
  assign isOp  = (offW[OFF_W-1:2] == (OFF_W-2)'(4));
  assign opIdx = offW[1:0];
  assign offOk = (isMp | isPa | isOp) & (mAddr[1:0] == 2'b00);

  logic [31:0] regRd;
  always_comb begin
    regRd = '0;
    if (isMp)      regRd = mpcr;
    else if (isPa) regRd = pacr0;
    else if (isOp) regRd = opacr[opIdx];
  end

  // rule checks
  logic [3:0] mpField, modField;
  logic effSup, trusted, unmapped, regSpace, slvBad, regBad;
  logic [SLOT_W-1:0] slot;
  logic [HI_W-1:0]   hiBits;

  assign regSpace = mAddr[ADDR_W-1];
  assign mpField  = mpcr[{mMaster, 2'b00} +: 4];
  assign effSup   = mSuper & mpField[0];
  assign trusted  = mWrite ? mpField[1] : mpField[2];
  assign slot     = mAddr[SLV_AW +: SLOT_W];
  assign hiBits   = mAddr[ADDR_W-2 -: HI_W];
  assign modField = aclFlat[{slot, 2'b00} +: 4];
  assign unmapped = (|hiBits) | (32'(slot) >= NUM_SLV) | (mAddr[1:0] != 2'b00);
  assign slvBad   = unmapped | (modField[2] & ~effSup) | (mWrite & modField[1])
                  | (modField[0] & ~trusted);
  assign regBad   = ~effSup | ~offOk | mFetch;

  always_comb begin
    dec.isReg = regSpace;
    dec.bad   = regSpace ? regBad : slvBad;
    dec.post  = ~regSpace & ~slvBad & mWrite & ~mFetch & modField[3];
  end

  function automatic logic [31:0] mergeBe(input logic [31:0] oldV,
                                          input logic [31:0] newV,
                                          input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? newV[8*b +: 8] : oldV[8*b +: 8];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mpcr  <= MP_RESET;
      pacr0 <= PA_RESET;
      for (int i = 0; i < OP_N; i++) opacr[i] <= OP_RESET;
    end else if (stb.regWr) begin
      if (isMp)      mpcr <= mergeBe(mpcr, laneWd, laneBe) & MP_MASK;
      else if (isPa) pacr0 <= mergeBe(pacr0, laneWd, laneBe);
      else if (isOp) opacr[opIdx] <= mergeBe(opacr[opIdx], laneWd, laneBe);
    end
  end

  // request hold and response assembly
  logic [SLV_AW-3:0] reqAddr;
  logic [3:0]        reqBe;
  logic [31:0]       reqWd, rdLo, rdHi;
  logic              reqWrite, errQ;
  logic [SLOT_W-1:0] slotQ;
  logic [31:0]       selWord;
  logic              selErr;

  assign selWord  = sRdata[32*slotQ +: 32];
  assign selErr   = sErr[slotQ];
  assign selReady = sReady[slotQ];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqBe    <= '0;
      reqWd    <= '0;
      reqWrite <= 1'b0;
      reqFetch <= 1'b0;
      slotQ    <= '0;
      errQ     <= 1'b0;
      rdLo     <= '0;
      rdHi     <= '0;
    end else begin
      if (stb.capture) begin
        reqAddr  <= mAddr[SLV_AW-1:2];
        reqBe    <= mFetch ? 4'hF : laneBe;
        reqWd    <= laneWd;
        reqWrite <= mWrite & ~mFetch;
        reqFetch <= mFetch;
        slotQ    <= slot;
        errQ     <= dec.bad;
        rdLo     <= regRd;
        rdHi     <= regRd;
      end
      if (stb.loadLo) begin
        rdLo <= selWord;
        if (!reqFetch) rdHi <= selWord;
        errQ <= errQ | selErr;
      end
      if (stb.loadHi) begin
        rdHi <= selWord;
        errQ <= errQ | selErr;
      end
    end
  end

  assign sValid = stb.drive ? (NUM_SLV'(1) << slotQ) : '0;
  assign sWrite = reqWrite;
  assign sBe    = reqBe;
  assign sWdata = reqWd;
  assign sAddr  = {reqAddr[SLV_AW-3:1], reqFetch ? stb.hiHalf : reqAddr[0], 2'b00};
  assign mErr   = errQ;
  assign mRdata = errQ ? 64'd0 : {rdHi, rdLo};

endmodule

// File: rtl/pb_ctrl.sv
module pb_ctrl
  import pb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      mValid,
  input  logic      mWrite,
  input  pbDecide_t dec,
  input  logic      reqFetch,
  input  logic      selReady,
  output logic      mReady,
  output logic      mRspValid,
  output pbStrobe_t stb
);

  pbState_e state, nextState;
  logic postQ;

  always_comb begin
    stb       = '0;
    nextState = state;
    mReady    = 1'b0;
    mRspValid = 1'b0;
    case (state)
      ST_IDLE: begin
        mReady = 1'b1;
        if (mValid) begin
          stb.capture = 1'b1;
          stb.regWr   = dec.isReg & ~dec.bad & mWrite;
          nextState   = (dec.bad | dec.isReg | dec.post) ? ST_RESP : ST_ACC;
        end
      end
      ST_ACC: begin
        stb.drive = 1'b1;
        if (selReady) begin
          stb.loadLo = 1'b1;
          nextState  = reqFetch ? ST_ACC2 : ST_RESP;
        end
      end
      ST_ACC2: begin
        stb.drive  = 1'b1;
        stb.hiHalf = 1'b1;
        if (selReady) begin
          stb.loadHi = 1'b1;
          nextState  = ST_RESP;
        end
      end
      ST_RESP: begin
        mRspValid = 1'b1;
        nextState = postQ ? ST_DRAIN : ST_IDLE;
      end
      ST_DRAIN: begin
        stb.drive = 1'b1;
        if (selReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      postQ <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.capture) postQ <= dec.post;
    end
  end

endmodule

// File: rtl/periph_bridge.sv
module periph_bridge
  import pb_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 16,
  parameter int SLV_AW  = 12,
  parameter int MST_W   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  mValid,
  output logic                  mReady,
  input  logic                  mWrite,
  input  logic                  mFetch,
  input  logic [MST_W-1:0]      mMaster,
  input  logic                  mSuper,
  input  logic [ADDR_W-1:0]     mAddr,
  input  logic [7:0]            mBe,
  input  logic [63:0]           mWdata,
  output logic                  mRspValid,
  output logic [63:0]           mRdata,
  output logic                  mErr,
  output logic [NUM_SLV-1:0]    sValid,
  input  logic [NUM_SLV-1:0]    sReady,
  output logic                  sWrite,
  output logic [SLV_AW-1:0]     sAddr,
  output logic [3:0]            sBe,
  output logic [31:0]           sWdata,
  input  logic [NUM_SLV*32-1:0] sRdata,
  input  logic [NUM_SLV-1:0]    sErr
);

  pbStrobe_t stb;
  pbDecide_t dec;
  logic      reqFetch;
  logic      selReady;

  pb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mValid    (mValid),
    .mWrite    (mWrite),
    .dec       (dec),
    .reqFetch  (reqFetch),
    .selReady  (selReady),
    .mReady    (mReady),
    .mRspValid (mRspValid),
    .stb       (stb)
  );

  pb_datapath #(
    .NUM_SLV (NUM_SLV),
    .ADDR_W  (ADDR_W),
    .SLV_AW  (SLV_AW),
    .MST_W   (MST_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .mWrite   (mWrite),
    .mFetch   (mFetch),
    .mMaster  (mMaster),
    .mSuper   (mSuper),
    .mAddr    (mAddr),
    .mBe      (mBe),
    .mWdata   (mWdata),
    .dec      (dec),
    .reqFetch (reqFetch),
    .selReady (selReady),
    .mRdata   (mRdata),
    .mErr     (mErr),
    .sValid   (sValid),
    .sReady   (sReady),
    .sWrite   (sWrite),
    .sAddr    (sAddr),
    .sBe      (sBe),
    .sWdata   (sWdata),
    .sRdata   (sRdata),
    .sErr     (sErr)
  );

endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 16,
  parameter int SLV_AW  = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               mValid,
  input logic               mReady,
  input logic               mSuper,
  input logic [ADDR_W-1:0]  mAddr,
  input logic               mRspValid,
  input logic               mErr,
  input logic [NUM_SLV-1:0] sValid,
  input logic [NUM_SLV-1:0] sReady,
  input logic [SLV_AW-1:0]  sAddr
);

  // R14: never more than one slave selected
  a_r14_one_slave: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sValid));

  // R14: request held steady until the slave completes
  a_r14_hold: assert property (@(posedge clk) disable iff (!rstN)
    (|(sValid & ~sReady)) |=> (sValid == $past(sValid)) && $stable(sAddr));

  // R12: no new master request accepted while a slave access is in flight
  a_r12_busy: assert property (@(posedge clk) disable iff (!rstN)
    (|sValid) |-> !mReady);

  // R3: user-mode register access is answered with an error next cycle
  a_r3_user_reg: assert property (@(posedge clk) disable iff (!rstN)
    (mValid && mReady && mAddr[ADDR_W-1] && !mSuper) |=> (mRspValid && mErr));

  // R10: one request at a time
  a_r10_single: assert property (@(posedge clk) disable iff (!rstN)
    (mValid && mReady) |=> !mReady);

endmodule

bind periph_bridge pb_checker #(
  .NUM_SLV (NUM_SLV),
  .ADDR_W  (ADDR_W),
  .SLV_AW  (SLV_AW)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .mValid    (mValid),
  .mReady    (mReady),
  .mSuper    (mSuper),
  .mAddr     (mAddr),
  .mRspValid (mRspValid),
  .mErr      (mErr),
  .sValid    (sValid),
  .sReady    (sReady),
  .sAddr     (sAddr)
);

// File: tb/sim_periph_bridge.sv
`timescale 1ns/1ps
module sim_periph_bridge;

  localparam int NS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic mValid = 0, mWrite = 0, mFetch = 0, mSuper = 0;
  logic [2:0] mMaster = 0;
  logic [15:0] mAddr = 0;
  logic [7:0] mBe = 0;
  logic [63:0] mWdata = 0;
  logic mReady, mRspValid, mErr;
  logic [63:0] mRdata;
  logic [NS-1:0] sValid, sReady, sErr;
  logic sWrite;
  logic [11:0] sAddr;
  logic [3:0] sBe;
  logic [31:0] sWdata;
  logic [NS*32-1:0] sRdata;

  periph_bridge u0 (
    .clk(clk), .rstN(rstN), .mValid(mValid), .mReady(mReady), .mWrite(mWrite),
    .mFetch(mFetch), .mMaster(mMaster), .mSuper(mSuper), .mAddr(mAddr), .mBe(mBe),
    .mWdata(mWdata), .mRspValid(mRspValid), .mRdata(mRdata), .mErr(mErr),
    .sValid(sValid), .sReady(sReady), .sWrite(sWrite), .sAddr(sAddr), .sBe(sBe),
    .sWdata(sWdata), .sRdata(sRdata), .sErr(sErr)
  );

  // slave model: word 15 of each slave answers with an error
  logic [31:0] mem [NS][16];
  int cnt [NS];
  int slvDelay = 1;
  int hsCount = 0;
  logic [11:0] lastAddr1, lastAddr2;
  logic [3:0] lastBe;
  int lastSlot;

  always @(posedge clk) begin
    if (!rstN) begin
      sReady <= '0; sErr <= '0; sRdata <= '0;
      for (int i = 0; i < NS; i++) begin
        cnt[i] <= 0;
        for (int w = 0; w < 16; w++) mem[i][w] <= '0;
      end
    end else begin
      for (int i = 0; i < NS; i++) begin
        if (sValid[i] && !sReady[i]) begin
          if (cnt[i] >= slvDelay) begin
            sReady[i] <= 1'b1;
            sRdata[32*i +: 32] <= mem[i][sAddr[5:2]];
            sErr[i] <= (sAddr[5:2] == 4'd15);
          end else cnt[i] <= cnt[i] + 1;
        end else begin
          if (sValid[i] && sReady[i]) begin
            if (sWrite)
              for (int b = 0; b < 4; b++)
                if (sBe[b]) mem[i][sAddr[5:2]][8*b +: 8] <= sWdata[8*b +: 8];
            hsCount <= hsCount + 1;
            lastAddr2 <= lastAddr1;
            lastAddr1 <= sAddr;
            lastBe <= sBe;
            lastSlot <= i;
          end
          sReady[i] <= 1'b0;
          sErr[i] <= 1'b0;
          cnt[i] <= 0;
        end
      end
    end
  end

  int total = 0, bad = 0;
  logic finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic [63:0] rd;
  logic er;

  task automatic acc(input logic [2:0] mst, input logic sup, input logic wr,
                     input logic fe, input logic [15:0] a, input logic [7:0] be,
                     input logic [63:0] wd);
    @(negedge clk);
    mValid = 1; mMaster = mst; mSuper = sup; mWrite = wr; mFetch = fe;
    mAddr = a; mBe = be; mWdata = wd;
    while (!mReady) @(negedge clk);
    @(negedge clk);
    mValid = 0;
    while (!mRspValid) @(negedge clk);
    rd = mRdata; er = mErr;
  endtask

  task automatic rdReg(input logic [15:0] a);
    acc(0, 1, 0, 0, a, 8'hFF, 0);
  endtask

  task automatic wrReg(input logic [15:0] a, input logic [31:0] v);
    acc(0, 1, 1, 0, a, a[2] ? 8'hF0 : 8'h0F, {v, v});
  endtask

  task automatic tReset();
    chk("R1 ready", mReady, 1);
    chk("R1 rsp", mRspValid, 0);
    chk("R14 sValid idle", sValid, 0);
    rdReg(16'h8000); chk("R1 mp", rd[31:0], 32'h7777_7777); chk("R1 mp err", er, 0);
    rdReg(16'h8020); chk("R1 pa0", rd[31:0], 32'h5444_4444);
    rdReg(16'h8040); chk("R1 op0", rd[31:0], 32'h4444_4444);
    rdReg(16'h8044); chk("R1 op1", rd[63:32], 32'h4444_4444);
    rdReg(16'h8048); chk("R1 op2", rd[31:0], 32'h4444_4444);
    rdReg(16'h804C); chk("R1 op3", rd[63:32], 32'h4444_4444);
  endtask

  task automatic tRegErr();
    rdReg(16'h8004); chk("R3 reserved", er, 1);
    acc(0, 0, 0, 0, 16'h8000, 8'h0F, 0); chk("R3 user read", er, 1);
    acc(0, 0, 1, 0, 16'h8020, 8'h0F, 0); chk("R3 user write", er, 1);
    rdReg(16'h8020); chk("R3 unchanged", rd[31:0], 32'h5444_4444);
    acc(0, 1, 0, 1, 16'h8000, 8'hFF, 0); chk("R3 fetch", er, 1);
  endtask

  task automatic tRegWrite();
    wrReg(16'h8020, 32'h0); rdReg(16'h8020); chk("R2 pa0 write", rd[31:0], 0);
    wrReg(16'h8000, 32'hFFFF_FFFF); rdReg(16'h8000);
    chk("R2 reserved bits", rd[31:0], 32'h7777_7777);
    acc(0, 1, 1, 0, 16'h8000, 8'h08, 64'h0); rdReg(16'h8000);
    chk("R2 byte write", rd[31:0], 32'h0077_7777);
    wrReg(16'h8000, 32'h7777_7777);
    acc(0, 1, 1, 0, 16'h8044, 8'hF0, {32'h1234_5678, 32'h0});
    rdReg(16'h8044); chk("R2 upper lane", rd[31:0], 32'h1234_5678);
    rdReg(16'h8040); chk("R2 neighbour", rd[31:0], 32'h4444_4444);
  endtask

  task automatic tSlave();
    int h;
    acc(0, 1, 1, 0, 16'h1008, 8'h0F, {32'h0, 32'hA5A5_1234});
    chk("R5 write be", lastBe, 4'hF); chk("R4 slave addr", lastAddr1, 12'h008);
    chk("R14 slot", lastSlot, 1);
    acc(0, 1, 0, 0, 16'h1008, 8'h0F, 0);
    chk("R5 read", rd, {32'hA5A5_1234, 32'hA5A5_1234});
    acc(0, 1, 1, 0, 16'h2004, 8'hF0, {32'hCAFE_F00D, 32'h0});
    acc(0, 1, 1, 0, 16'h2004, 8'h20, {32'h0000_5500, 32'h0});
    chk("R5 byte be", lastBe, 4'b0010);
    acc(0, 1, 0, 0, 16'h2004, 8'hF0, 0); chk("R5 byte merge", rd[63:32], 32'hCAFE_550D);
    acc(0, 1, 1, 0, 16'h2000, 8'h0C, {32'h0, 32'hBEEF_0000});
    acc(0, 1, 0, 0, 16'h2000, 8'h0F, 0); chk("R5 halfword", rd[31:0], 32'hBEEF_0000);
    h = hsCount;
    acc(0, 1, 0, 0, 16'h4000, 8'h0F, 0); chk("R4 unmapped err", er, 1);
    acc(0, 1, 0, 0, 16'h1009, 8'h0F, 0); chk("R4 misaligned err", er, 1);
    chk("R10 no handshake", hsCount, h);
  endtask

  task automatic tFetch();
    int h;
    acc(0, 1, 1, 0, 16'h3000, 8'h0F, {32'h0, 32'h1111_1111});
    acc(0, 1, 1, 0, 16'h3004, 8'hF0, {32'h2222_2222, 32'h0});
    h = hsCount;
    acc(0, 1, 0, 1, 16'h3004, 8'hFF, 0);
    chk("R6 data", rd, 64'h2222_2222_1111_1111); chk("R6 err", er, 0);
    chk("R6 first lower", lastAddr2, 12'h000); chk("R6 then upper", lastAddr1, 12'h004);
    chk("R6 two accesses", hsCount, h + 2);
    acc(0, 1, 0, 1, 16'h3038, 8'hFF, 0); chk("R6 half err", er, 1);
  endtask

  task automatic tSlvErr();
    acc(0, 1, 0, 0, 16'h203C, 8'h0F, 0); chk("R13 read err", er, 1);
    acc(0, 1, 1, 0, 16'h103C, 8'h0F, 0); chk("R13 write err", er, 1);
  endtask

  task automatic tProtect();
    int h;
    wrReg(16'h8020, 32'h0000_8124);
    wrReg(16'h8000, 32'h7775_3677);
    h = hsCount;
    acc(0, 0, 0, 0, 16'h0000, 8'h0F, 0); chk("R7 user blocked", er, 1);
    acc(2, 1, 0, 0, 16'h0000, 8'h0F, 0); chk("R7 forced user", er, 1);
    acc(0, 1, 1, 0, 16'h1008, 8'h0F, 0); chk("R8 write protect", er, 1);
    acc(3, 1, 0, 0, 16'h2000, 8'h0F, 0); chk("R9 untrusted read", er, 1);
    acc(4, 1, 1, 0, 16'h2008, 8'h0F, 0); chk("R9 untrusted write", er, 1);
    chk("R10 blocked no handshake", hsCount, h);
    acc(0, 1, 0, 0, 16'h0000, 8'h0F, 0); chk("R7 supervisor ok", er, 0);
    acc(0, 1, 0, 0, 16'h1008, 8'h0F, 0); chk("R8 read ok", rd[31:0], 32'hA5A5_1234);
    acc(3, 1, 1, 0, 16'h2008, 8'h0F, {32'h0, 32'h0000_0042}); chk("R9 trusted write", er, 0);
    acc(4, 1, 0, 0, 16'h2008, 8'h0F, 0); chk("R9 trusted read", rd[31:0], 32'h42);
  endtask

  task automatic tPosted();
    int h;
    slvDelay = 6;
    h = hsCount;
    acc(0, 1, 1, 0, 16'h3008, 8'h0F, {32'h0, 32'h0000_0077});
    chk("R11 early rsp err", er, 0);
    chk("R11 before slave done", hsCount, h);
    @(negedge clk); chk("R12 ready low", mReady, 0);
    acc(0, 1, 0, 0, 16'h3008, 8'h0F, 0);
    chk("R12 ordered read", rd[31:0], 32'h77);
    acc(0, 1, 1, 0, 16'h303C, 8'h0F, 0); chk("R11 slave err dropped", er, 0);
    acc(0, 1, 0, 0, 16'h3008, 8'h0F, 0); chk("R12 after drain", rd[31:0], 32'h77);
    slvDelay = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tRegErr();
    tRegWrite();
    tSlave();
    tFetch();
    tSlvErr();
    tProtect();
    tPosted();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule